// File: doc/BRIEF.md
# Split-Port Double-Data-Rate Burst-of-Two Memory

This block is a synchronous memory with one port that only reads and one port that only writes. The two ports share a single address bus. The read port takes its address on the rising edge of K, and the write port takes its address on the falling half of the same K period (the K# rising edge). Every access moves a double-width line as two words, one per K half-cycle. The lower half of the line always moves first. Because the data-in and data-out buses are separate, a read and a write can start in the same K period and no bus turnaround is needed.

The block runs from one system clock at twice the K rate. Consecutive system-clock edges alternate between K rising and K# rising, and the first edge after reset is a K rising edge. Each write beat has its own active-low byte enables. When a read and a write hit the same line, the read returns the newest contents. The output-enable flag is high only while a read beat is on the bus. A strap input, sampled during reset, sets the output timing. In shared-clock mode the output register follows K and K#. In split-clock mode the output clocks are taken to trail K by half a K period, so every read beat leaves one system-clock edge later.

Top module: `sdp_ddr_sram`

## Requirements
- R1: While reset is high, and after it until the first read beat, `rdata_oe` is 0 and `rdata` is 0. After reset every line of the array reads as zero.
- R2: With `strap_one_clk` high during reset, a read is selected when `rd_sel_n` is 0 at a K rising edge r, and `addr` is captured on that edge. Bits [WORD_W-1:0] of the line appear on `rdata` after edge r+2. Bits [2*WORD_W-1:WORD_W] appear after edge r+3.
- R3: `rdata_oe` is 1 exactly for the edges that carry a read beat, so beats always come in pairs. When `rdata_oe` is 0, `rdata` is 0.
- R4: A write is selected when `wr_sel_n` is 0 at a K rising edge. `wdata` on that edge goes to the lower half of the line. On the following K# edge, `addr` and `wdata` are captured again, and that second word goes to the upper half.
- R5: `wbe_n[i]`=0 enables byte `wdata[i*BYTE_W +: BYTE_W]` of the beat being captured. Each beat samples its own enables. A disabled byte keeps its stored value.
- R6: The select inputs are sampled only at K rising edges. A low `rd_sel_n` or `wr_sel_n` at a K# edge starts nothing. A write whose select goes high on its second beat still completes.
- R7: A read and a write can be selected on the same K edge, or on any sequence of K edges, and neither disturbs the other. Reads on consecutive K edges give an unbroken stream of beats.
- R8: A read returns the line as changed by every write whose K rising edge is at or before the read's K rising edge. This includes a write begun on that same edge or on the edge before it. It does not include any write begun later.
- R9: With `strap_one_clk` low during reset, every `rdata`/`rdata_oe` event of R2 and R3 happens one system-clock edge later. The strap is ignored outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at twice the K rate; edges alternate K rise / K# rise |
| rst | input | 1 | Synchronous active-high reset |
| strap_one_clk | input | 1 | Output timing strap, sampled during reset (1 = shared clock) |
| rd_sel_n | input | 1 | Active-low read select, sampled at K rise |
| wr_sel_n | input | 1 | Active-low write select, sampled at K rise |
| addr | input | ADDR_W | Shared address: read address at K rise, write address at K# rise |
| wdata | input | BYTE_W*NBYTES | Write data word, one per edge of a write |
| wbe_n | input | NBYTES | Active-low byte enables for the current write beat |
| rdata | output | BYTE_W*NBYTES | Read data word; zero when not driven |
| rdata_oe | output | 1 | High while a read beat is on `rdata` |

## Verification
The two functions that meet in one cycle are the write commit and the read fetch. A write begun on a K edge commits its line on the next K edge, and that is the same edge on which a read selected alongside it takes its data. The bench causes this by asserting both selects on one K edge for the same address, with different byte-enable masks on each beat. It also uses a write-then-read pair one K period apart, and a long random mix limited to eight addresses so that collisions are frequent. Each read is judged against a shadow memory that applies every write on its second beat, before it resolves any read begun on the same K edge. The expected line therefore holds the merged bytes that the masks allow, and nothing from later writes.

// File: rtl/sdp_sram_pkg.sv
package sdp_sram_pkg;

    // Which half of the K period the next system-clock edge belongs to.
    typedef enum logic {
        PH_K  = 1'b0,
        PH_KN = 1'b1
    } kphase_t;

    // Output register timing chosen by the strap during reset.
    typedef enum logic {
        OCLK_SPLIT  = 1'b0,
        OCLK_SHARED = 1'b1
    } oclk_mode_t;

    function automatic kphase_t next_phase(kphase_t p);
        return (p == PH_K) ? PH_KN : PH_K;
    endfunction

    function automatic oclk_mode_t strap_mode(logic one_clk);
        return one_clk ? OCLK_SHARED : OCLK_SPLIT;
    endfunction

endpackage

// File: rtl/sdp_wr_capture.sv
module sdp_wr_capture #(
    parameter int ADDR_W = 4,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2,
    localparam int WORD_W = BYTE_W * NBYTES,
    localparam int LINE_W = 2 * WORD_W,
    localparam int LANES  = 2 * NBYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              k_rise,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [NBYTES-1:0] wbe_n,
    output logic              commit_vld,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [LINE_W-1:0] commit_line,
    output logic [LANES-1:0]  commit_en
);

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
        logic [NBYTES-1:0] en;
    } beat_t;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [LINE_W-1:0] line;
        logic [LANES-1:0]  en;
    } wline_t;

    beat_t  first_q;
    wline_t pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= '0;
            pend_q  <= '0;
        end else if (k_rise) begin
            // first beat; select is only looked at here
            first_q.vld  <= !wr_sel_n;
            first_q.data <= wdata;
            first_q.en   <= ~wbe_n;
            // a completed line commits on this edge and leaves
            pend_q.vld   <= 1'b0;
        end else begin
            first_q.vld <= 1'b0;
            if (first_q.vld) begin
                pend_q.vld  <= 1'b1;
                pend_q.addr <= addr;
                pend_q.line <= {wdata, first_q.data};
                pend_q.en   <= {~wbe_n, first_q.en};
            end
        end
    end

    assign commit_vld  = pend_q.vld;
    assign commit_addr = pend_q.addr;
    assign commit_line = pend_q.line;
    assign commit_en   = pend_q.en;

endmodule

// File: rtl/sdp_line_array.sv
module sdp_line_array #(
    parameter int ADDR_W = 4,
    parameter int BYTE_W = 9,
    parameter int LANES  = 4,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int LINE_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LINE_W-1:0] wline,
    input  logic [LANES-1:0]  wen,
    input  logic [ADDR_W-1:0] raddr,
    output logic [LINE_W-1:0] rline
);

    logic [LINE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (wen[l]) begin
                    mem_q[waddr][l*BYTE_W +: BYTE_W] <= wline[l*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    assign rline = mem_q[raddr];

endmodule

// File: rtl/sdp_rd_pipe.sv
module sdp_rd_pipe #(
    parameter int ADDR_W = 4,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2,
    localparam int WORD_W = BYTE_W * NBYTES,
    localparam int LINE_W = 2 * WORD_W,
    localparam int LANES  = 2 * NBYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              k_rise,
    input  logic              mode_single,
    input  logic              rd_sel_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] arr_raddr,
    input  logic [LINE_W-1:0] arr_line,
    input  logic              fwd_vld,
    input  logic [ADDR_W-1:0] fwd_addr,
    input  logic [LINE_W-1:0] fwd_line,
    input  logic [LANES-1:0]  fwd_en,
    output logic [WORD_W-1:0] rdata,
    output logic              rdata_oe
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } rreq_t;

    typedef struct packed {
        logic              oe;
        logic [WORD_W-1:0] q;
    } obeat_t;

    rreq_t             req_q;
    obeat_t            near_q;
    obeat_t            far_q;
    logic [WORD_W-1:0] hi_q;
    logic              hi_vld_q;
    logic [LINE_W-1:0] fetched;
    logic              fwd_hit;

    assign arr_raddr = req_q.addr;
    assign fwd_hit   = fwd_vld && (fwd_addr == req_q.addr);

    // a line committing on the fetch edge overrides the array byte by byte
    for (genvar l = 0; l < LANES; l++) begin : g_fwd
        assign fetched[l*BYTE_W +: BYTE_W] = (fwd_hit && fwd_en[l])
                                           ? fwd_line[l*BYTE_W +: BYTE_W]
                                           : arr_line[l*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= '0;
            near_q   <= '0;
            far_q    <= '0;
            hi_q     <= '0;
            hi_vld_q <= 1'b0;
        end else begin
            if (k_rise) begin
                req_q.vld  <= !rd_sel_n;
                req_q.addr <= addr;
                if (req_q.vld) begin
                    near_q   <= '{oe: 1'b1, q: fetched[WORD_W-1:0]};
                    hi_q     <= fetched[LINE_W-1:WORD_W];
                    hi_vld_q <= 1'b1;
                end else begin
                    near_q   <= '0;
                    hi_vld_q <= 1'b0;
                end
            end else begin
                if (hi_vld_q) begin
                    near_q <= '{oe: 1'b1, q: hi_q};
                end else begin
                    near_q <= '0;
                end
                hi_vld_q <= 1'b0;
            end
            // output clocks trailing K by half a period
            far_q <= near_q;
        end
    end

    assign rdata_oe = mode_single ? near_q.oe : far_q.oe;
    assign rdata    = mode_single ? near_q.q  : far_q.q;

endmodule

// File: rtl/sdp_ddr_sram.sv
module sdp_ddr_sram
    import sdp_sram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     strap_one_clk,
    input  logic                     rd_sel_n,
    input  logic                     wr_sel_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [BYTE_W*NBYTES-1:0] wdata,
    input  logic [NBYTES-1:0]        wbe_n,
    output logic [BYTE_W*NBYTES-1:0] rdata,
    output logic                     rdata_oe
);

    localparam int WORD_W = BYTE_W * NBYTES;
    localparam int LINE_W = 2 * WORD_W;
    localparam int LANES  = 2 * NBYTES;

    kphase_t    kph;
    oclk_mode_t omode;
    logic       k_rise;
    logic       mode_single;

    always_ff @(posedge clk) begin
        if (rst) begin
            kph   <= PH_K;
            omode <= strap_mode(strap_one_clk);
        end else begin
            kph <= next_phase(kph);
        end
    end

    assign k_rise      = (kph == PH_K);
    assign mode_single = (omode == OCLK_SHARED);

    logic              commit_vld;
    logic [ADDR_W-1:0] commit_addr;
    logic [LINE_W-1:0] commit_line;
    logic [LANES-1:0]  commit_en;
    logic [ADDR_W-1:0] arr_raddr;
    logic [LINE_W-1:0] arr_line;

    sdp_wr_capture #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)
    ) i_wr (
        .clk        (clk),
        .rst        (rst),
        .k_rise     (k_rise),
        .wr_sel_n   (wr_sel_n),
        .addr       (addr),
        .wdata      (wdata),
        .wbe_n      (wbe_n),
        .commit_vld (commit_vld),
        .commit_addr(commit_addr),
        .commit_line(commit_line),
        .commit_en  (commit_en)
    );

    sdp_line_array #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)
    ) i_arr (
        .clk  (clk),
        .rst  (rst),
        .we   (commit_vld && k_rise),
        .waddr(commit_addr),
        .wline(commit_line),
        .wen  (commit_en),
        .raddr(arr_raddr),
        .rline(arr_line)
    );

    sdp_rd_pipe #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)
    ) i_rd (
        .clk        (clk),
        .rst        (rst),
        .k_rise     (k_rise),
        .mode_single(mode_single),
        .rd_sel_n   (rd_sel_n),
        .addr       (addr),
        .arr_raddr  (arr_raddr),
        .arr_line   (arr_line),
        .fwd_vld    (commit_vld && k_rise),
        .fwd_addr   (commit_addr),
        .fwd_line   (commit_line),
        .fwd_en     (commit_en),
        .rdata      (rdata),
        .rdata_oe   (rdata_oe)
    );

endmodule

// File: rtl/sdp_ddr_sram_chk.sv
module sdp_ddr_sram_chk #(
    parameter int WORD_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              k_rise,
    input logic              mode_single,
    input logic              rd_sel_n,
    input logic              rdata_oe,
    input logic [WORD_W-1:0] rdata
);

    // R3
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rdata_oe |-> (rdata == '0));

    // R2
    rd_shared_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (k_rise && !rd_sel_n && mode_single) |-> ##3 rdata_oe ##1 rdata_oe);

    // R9
    rd_split_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (k_rise && !rd_sel_n && !mode_single) |-> ##4 rdata_oe ##1 rdata_oe);

    // R3
    beat_pair_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rdata_oe) |=> rdata_oe);

    // R6
    oe_origin_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_single && $rose(rdata_oe)) |-> $past(k_rise && !rd_sel_n, 3));

endmodule

bind sdp_ddr_sram sdp_ddr_sram_chk #(.WORD_W(WORD_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .k_rise     (k_rise),
    .mode_single(mode_single),
    .rd_sel_n   (rd_sel_n),
    .rdata_oe   (rdata_oe),
    .rdata      (rdata)
);

// File: tb/test_sdp_ddr_sram.sv
`timescale 1ns/1ps
module test_sdp_ddr_sram;

    localparam int AW = 4;
    localparam int BW = 9;
    localparam int NB = 2;
    localparam int WW = BW * NB;
    localparam int LW = 2 * WW;
    localparam int DEPTH = 1 << AW;
    localparam int NE = 4096;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strap = 1'b1;
    logic          rs_n = 1'b1;
    logic          ws_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [WW-1:0] wd = '0;
    logic [NB-1:0] be_n = '1;
    logic [WW-1:0] rq;
    logic          roe;

    always #2.5 clk = ~clk;

    sdp_ddr_sram #(.ADDR_W(AW), .BYTE_W(BW), .NBYTES(NB)) i_sdp_ddr_sram (
        .clk(clk), .rst(rst), .strap_one_clk(strap),
        .rd_sel_n(rs_n), .wr_sel_n(ws_n), .addr(addr),
        .wdata(wd), .wbe_n(be_n), .rdata(rq), .rdata_oe(roe)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [LW-1:0] shadow [DEPTH];
    logic          exp_oe [NE];
    logic [WW-1:0] exp_q [NE];
    string         exp_tag [NE];
    int            e;
    int            lag;
    string         tag;
    logic          pw_vld;
    logic [WW-1:0] pw_d0;
    logic [NB-1:0] pw_m0;
    logic          rd_vld;
    logic [AW-1:0] rd_addr;
    int            rd_edge;
    string         rd_tag;
    logic [31:0]   rnd = 32'h1234_5678;

    task automatic check(input string t, input logic [WW-1:0] act, input logic [WW-1:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s edge=%0d actual=%h expected=%h", t, e, act, expv);
        end
    endtask

    function automatic logic [WW-1:0] fd(input int a, input int salt);
        return WW'((a * 2741 + salt * 977 + 41) % (1 << WW));
    endfunction

    function automatic logic [31:0] step_rnd(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic clear_model();
        for (int i = 0; i < NE; i++) begin
            exp_oe[i] = 1'b0;
            exp_q[i] = '0;
            exp_tag[i] = "R3";
        end
        for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
        pw_vld = 1'b0;
        rd_vld = 1'b0;
        e = 0;
    endtask

    task automatic do_reset(input bit single);
        @(negedge clk);
        strap = single;
        rst = 1'b1;
        rs_n = 1'b1; ws_n = 1'b1; be_n = '1;
        repeat (3) begin
            @(negedge clk);
            check("R1 oe in reset", WW'(roe), '0);
            check("R1 data in reset", rq, '0);
        end
        rst = 1'b0;
        clear_model();
        lag = single ? 0 : 1;
    endtask

    // one system-clock edge: drive, model it, step, compare
    task automatic half(input bit rs, input bit ws, input logic [AW-1:0] a,
                        input logic [WW-1:0] d, input logic [NB-1:0] m);
        rs_n = rs; ws_n = ws; addr = a; wd = d; be_n = m;
        if (e % 2 == 0) begin
            if (!ws) begin pw_vld = 1'b1; pw_d0 = d; pw_m0 = m; end
            if (!rs) begin rd_vld = 1'b1; rd_addr = a; rd_edge = e; rd_tag = tag; end
        end else begin
            if (pw_vld) begin
                for (int l = 0; l < NB; l++) begin
                    if (!pw_m0[l]) shadow[a][l*BW +: BW] = pw_d0[l*BW +: BW];
                    if (!m[l]) shadow[a][WW + l*BW +: BW] = d[l*BW +: BW];
                end
                pw_vld = 1'b0;
            end
            if (rd_vld) begin
                exp_oe[rd_edge + 2 + lag] = 1'b1;
                exp_q[rd_edge + 2 + lag] = shadow[rd_addr][WW-1:0];
                exp_tag[rd_edge + 2 + lag] = rd_tag;
                exp_oe[rd_edge + 3 + lag] = 1'b1;
                exp_q[rd_edge + 3 + lag] = shadow[rd_addr][LW-1:WW];
                exp_tag[rd_edge + 3 + lag] = rd_tag;
                rd_vld = 1'b0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check("R3 output enable", WW'(roe), WW'(exp_oe[e]));
        if (exp_oe[e]) check(exp_tag[e], rq, exp_q[e]);
        else check("R3 idle data", rq, '0);
        e++;
    endtask

    task automatic kcyc(input bit rs, input bit ws, input logic [AW-1:0] ra,
                        input logic [WW-1:0] d0, input logic [NB-1:0] m0,
                        input logic [AW-1:0] wa, input logic [WW-1:0] d1,
                        input logic [NB-1:0] m1);
        half(rs, ws, ra, d0, m0);
        half(1'b1, 1'b1, wa, d1, m1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) half(1'b1, 1'b1, '0, '0, '1);
    endtask

    task automatic read_all(input bit gap);
        for (int a = 0; a < DEPTH; a++) begin
            kcyc(1'b0, 1'b1, AW'(a), '0, '1, '0, '0, '1);
            if (gap) idle(2);
        end
        idle(6);
    endtask

    task automatic random_mix(input int n);
        for (int i = 0; i < n; i++) begin
            rnd = step_rnd(rnd);
            kcyc(rnd[0], rnd[1], AW'(rnd[4:2]), fd(int'(rnd[12:5]), 7), rnd[14:13],
                 AW'(rnd[17:15]), fd(int'(rnd[25:18]), 9), rnd[27:26]);
        end
        idle(8);
    endtask

    initial begin
        // shared-clock run
        tag = "R1";
        do_reset(1'b1);
        idle(4);
        read_all(1'b0);      // zero after reset, R1

        tag = "R4";
        for (int a = 0; a < DEPTH; a++)
            kcyc(1'b1, 1'b0, '0, fd(a, 0), '0, AW'(a), fd(a, 1), '0);
        idle(2);
        read_all(1'b0);
        tag = "R2";
        read_all(1'b1);

        tag = "R5";
        for (int c = 0; c < DEPTH; c++)
            kcyc(1'b1, 1'b0, '0, fd(c, 2), NB'(c), AW'(c), fd(c, 3), NB'(c >> 2));
        idle(2);
        read_all(1'b0);

        tag = "R6";
        for (int a = 0; a < DEPTH; a++) begin
            half(1'b1, 1'b1, '0, '0, '1);
            half(1'b0, 1'b0, AW'(a), fd(a, 5), '0);
        end
        kcyc(1'b1, 1'b0, '0, fd(3, 6), '0, 4'd3, fd(3, 7), '0);
        idle(2);
        read_all(1'b0);

        tag = "R8";
        for (int a = 0; a < DEPTH; a++) begin
            kcyc(1'b0, 1'b0, AW'(a), fd(a, 11), NB'(a), AW'(a), fd(a, 12), NB'(a + 1));
            kcyc(1'b1, 1'b0, '0, fd(a, 13), NB'(a >> 1), AW'(a), fd(a, 14), '0);
            kcyc(1'b0, 1'b0, AW'(a), fd(a, 15), '0, AW'(a), fd(a, 16), '0);
            idle(4);
        end

        tag = "R7";
        random_mix(500);

        // split-clock run
        tag = "R9";
        do_reset(1'b0);
        for (int a = 0; a < DEPTH; a++)
            kcyc(1'b1, 1'b0, '0, fd(a, 20), NB'(a), AW'(a), fd(a, 21), '0);
        idle(2);
        read_all(1'b0);
        read_all(1'b1);
        random_mix(200);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule